// File: doc/BRIEF.md
# Programmable Power-of-Two Divider Timer

This block is a 24-stage binary counter chain, built as a synchronous equivalent of a ripple divider. One stage of the chain is routed to a single timing output, so the block divides its clock by a power of two chosen by a 4-bit select. A bypass input takes the lowest 8-stage section out of the path and feeds the clock straight into the ninth stage, which shortens every ratio by 2^8. After the chain is cleared, the output stays low for one timing interval and then goes high. Two hold inputs freeze the chain. A preset loads all ones and a clear loads all zeros.

Raising bypass, preset and clear together puts the block in a test configuration. In that configuration each of the three 8-stage sections steps on every clock by itself, so every stage can be exercised in 256 clocks instead of 2^24. A pulse option turns each rising edge of the selected stage into an output high for exactly one clock cycle.

Section width and section count are parameters. The defaults give 3 sections of 8 stages. The select width is derived from them.

Top module: `pow2_divider_timer`

## Requirements
- R1: While `rst` is high at a clock edge, every stage and the pulse history register load 0, so after reset `count_o` is 0 and `tap_out` is 0.
- R2: With `skip_low` low and no other control active, the chain counts up by one on every clock edge (stage 1 is bit 0 of `count_o`). Select value k routes stage k+9 to `tap_out`, whose period is then 2^(k+9) clocks.
- R3: With `skip_low` high and no other control active, bits 7..0 of `count_o` hold. Bits 23..8 count up by one per clock. Select value k routes stage k+9 to `tap_out`, which now has a period of 2^(k+1) clocks.
- R4: After `clear` falls, `tap_out` stays low for exactly 2^(n-1) counting clocks and then rises. Here n is k+9 without bypass and k+1 with bypass.
- R5: `clear` high (outside the test configuration) loads all zeros. It wins over `preset`, `clk_hold` and `osc_hold`.
- R6: `preset` high with `clear` low loads all ones, even when a hold is active.
- R7: Either `clk_hold` or `osc_hold` high, with neither `clear` nor `preset` high, leaves `count_o` unchanged across the edge.
- R8: With `skip_low`, `preset` and `clear` all high, each 8-bit section of `count_o` steps by one per clock modulo 256, with no carry between sections. Starting from zero, all stages read one after 255 clocks and zero after 256.
- R9: With `pulse_mode` high, `tap_out` is high for exactly one clock cycle after each rising edge of the selected stage, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| osc_hold | input | 1 | Hold request from the clock source side; freezes the chain |
| clk_hold | input | 1 | Clock hold; freezes the chain |
| preset | input | 1 | Load all ones |
| clear | input | 1 | Load all zeros |
| skip_low | input | 1 | Bypass the lowest section |
| tap_sel | input | 4 | Stage select k |
| pulse_mode | input | 1 | One-cycle pulse on each rise of the tap |
| tap_out | output | 1 | Divided or pulsed timing output |
| count_o | output | 24 | Present state of all stages |

## Verification
Every select value is run after a clear with bypass off and then with bypass on. The bench measures both the delay to the first rise and the rise-to-rise period, which separates the initial-interval behaviour from the steady divide ratio and catches an off-by-one tap. A preset followed by one bypassed clock shows whether the low section really holds while the upper sections wrap. Preset and clear combined with holds show the priority order.

The test configuration is run from zero for 15, 255 and 256 clocks on a narrow build and on the default build. Section-wise wrapping (0x0F0F0F) tells independent sections apart from a carried chain. A run in pulse mode checks the pulse count and width.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    typedef enum logic [2:0] {
        MODE_RUN,
        MODE_HOLD,
        MODE_CLEAR,
        MODE_PRESET,
        MODE_TEST
    } chain_mode_e;

    typedef struct packed {
        chain_mode_e mode;
        logic        skip;
    } chain_ctl_t;

    // Priority: test configuration, clear, preset, hold, run
    function automatic chain_ctl_t decode_ctl(
        input logic hold,
        input logic preset,
        input logic clear,
        input logic skip
    );
        chain_ctl_t c;
        c.skip = skip;
        if (skip && preset && clear) c.mode = MODE_TEST;
        else if (clear)              c.mode = MODE_CLEAR;
        else if (preset)             c.mode = MODE_PRESET;
        else if (hold)               c.mode = MODE_HOLD;
        else                         c.mode = MODE_RUN;
        return c;
    endfunction

endpackage

// File: rtl/pdt_ctl.sv
module pdt_ctl
    import pdt_pkg::*;
(
    input  logic       osc_hold,
    input  logic       clk_hold,
    input  logic       preset,
    input  logic       clear,
    input  logic       skip_low,
    output chain_ctl_t ctl
);

    logic any_hold;

    assign any_hold = osc_hold | clk_hold;

    always_comb begin
        ctl = decode_ctl(any_hold, preset, clear, skip_low);
    end

endmodule

// File: rtl/pdt_chain.sv
module pdt_chain
    import pdt_pkg::*;
#(
    parameter int SECT  = 8,
    parameter int NSECT = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  chain_ctl_t              ctl,
    output logic [SECT*NSECT-1:0]   count_o
);

    localparam int STAGES = SECT * NSECT;

    logic [NSECT-1:0] run_ci;
    logic [NSECT-1:0] sec_full;

    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        logic [SECT-1:0] sec_q;

        assign sec_full[g] = &sec_q;
        assign count_o[g*SECT +: SECT] = sec_q;

        if (g == 0) begin : g_first
            assign run_ci[g] = ~ctl.skip;
        end else if (g == 1) begin : g_second
            assign run_ci[g] = ctl.skip | (run_ci[g-1] & sec_full[g-1]);
        end else begin : g_upper
            assign run_ci[g] = run_ci[g-1] & sec_full[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sec_q <= '0;
            end else begin
                unique case (ctl.mode)
                    MODE_CLEAR:  sec_q <= '0;
                    MODE_PRESET: sec_q <= '1;
                    MODE_TEST:   sec_q <= sec_q + 1'b1;
                    MODE_RUN:    sec_q <= run_ci[g] ? sec_q + 1'b1 : sec_q;
                    default:     sec_q <= sec_q;
                endcase
            end
        end

        // R8
        test_sect_step_chk: assert property (@(posedge clk) disable iff (rst)
            (ctl.mode == MODE_TEST) |=>
                (count_o[g*SECT +: SECT] == $past(count_o[g*SECT +: SECT]) + SECT'(1)));
    end

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MODE_CLEAR) |=> (count_o == '0));

    // R6
    preset_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MODE_PRESET) |=> (count_o == '1));

    // R7
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MODE_HOLD) |=> $stable(count_o));

    // R3
    bypass_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MODE_RUN && ctl.skip) |=> $stable(count_o[SECT-1:0]));

    // R2
    run_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MODE_RUN && !ctl.skip) |=>
            (count_o == $past(count_o) + STAGES'(1)));

endmodule

// File: rtl/pdt_tap.sv
module pdt_tap #(
    parameter int STAGES = 24,
    parameter int SECT   = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] count_i,
    input  logic [SEL_W-1:0]  sel,
    input  logic              pulse_mode,
    output logic              tap_o
);

    localparam int IDX_W = $clog2(STAGES);
    localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(SECT);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(STAGES - 1);

    logic [IDX_W-1:0] idx_raw;
    logic [IDX_W-1:0] idx;
    logic             tap_bit;
    logic             tap_prev;

    assign idx_raw = IDX_BASE + IDX_W'(sel);
    assign idx     = (idx_raw > IDX_TOP) ? IDX_TOP : idx_raw;
    assign tap_bit = count_i[idx];

    always_ff @(posedge clk) begin
        if (rst) tap_prev <= 1'b0;
        else     tap_prev <= tap_bit;
    end

    assign tap_o = pulse_mode ? (tap_bit & ~tap_prev) : tap_bit;

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_mode && tap_o) |=> !(pulse_mode && tap_o));

    // R9
    pulse_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_mode && tap_o) |-> tap_bit);

endmodule

// File: rtl/pow2_divider_timer.sv
module pow2_divider_timer
    import pdt_pkg::*;
#(
    parameter int SECT  = 8,
    parameter int NSECT = 3,
    localparam int STAGES = SECT * NSECT,
    localparam int SEL_W  = $clog2((NSECT - 1) * SECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_hold,
    input  logic              clk_hold,
    input  logic              preset,
    input  logic              clear,
    input  logic              skip_low,
    input  logic [SEL_W-1:0]  tap_sel,
    input  logic              pulse_mode,
    output logic              tap_out,
    output logic [STAGES-1:0] count_o
);

    chain_ctl_t ctl;

    pdt_ctl u_ctl (
        .osc_hold (osc_hold),
        .clk_hold (clk_hold),
        .preset   (preset),
        .clear    (clear),
        .skip_low (skip_low),
        .ctl      (ctl)
    );

    pdt_chain #(
        .SECT  (SECT),
        .NSECT (NSECT)
    ) u_chain (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .count_o (count_o)
    );

    pdt_tap #(
        .STAGES (STAGES),
        .SECT   (SECT),
        .SEL_W  (SEL_W)
    ) u_tap (
        .clk        (clk),
        .rst        (rst),
        .count_i    (count_o),
        .sel        (tap_sel),
        .pulse_mode (pulse_mode),
        .tap_o      (tap_out)
    );

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clear && !(skip_low && preset)) |=> (count_o == '0));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (count_o == '0));

endmodule

// File: tb/test_pow2_divider_timer.sv
module test_pow2_divider_timer;

    localparam int SM_SECT  = 4;
    localparam int SM_NSECT = 3;
    localparam int SM_ST    = SM_SECT * SM_NSECT;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst = 1'b1;
    logic             osc_hold = 1'b0;
    logic             clk_hold = 1'b0;
    logic             preset = 1'b0;
    logic             clear = 1'b0;
    logic             skip_low = 1'b0;
    logic [2:0]       tap_sel = '0;
    logic             pulse_mode = 1'b0;
    logic             tap_out;
    logic [SM_ST-1:0] count_o;

    logic [3:0]  full_sel = '0;
    logic        full_tap;
    logic [23:0] full_count;

    pow2_divider_timer #(.SECT(SM_SECT), .NSECT(SM_NSECT)) i_pow2_divider_timer (
        .clk(clk), .rst(rst), .osc_hold(osc_hold), .clk_hold(clk_hold),
        .preset(preset), .clear(clear), .skip_low(skip_low), .tap_sel(tap_sel),
        .pulse_mode(pulse_mode), .tap_out(tap_out), .count_o(count_o)
    );

    pow2_divider_timer i_pow2_divider_timer_full (
        .clk(clk), .rst(rst), .osc_hold(osc_hold), .clk_hold(clk_hold),
        .preset(preset), .clear(clear), .skip_low(skip_low), .tap_sel(full_sel),
        .pulse_mode(pulse_mode), .tap_out(full_tap), .count_o(full_count)
    );

    int    vectors = 0;
    int    misses = 0;
    int    mon_vectors = 0;
    int    mon_misses = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    done = 1'b0;
    int    since = 0;
    logic  prev_tap = 1'b0;

    task automatic check(string req, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: measures rise intervals of tap_out and scores them against the queue
    always begin
        int    e;
        string t;
        @(posedge clk);
        if (rst || clear || preset) since = 0;
        else if (!(clk_hold || osc_hold)) since++;
        @(negedge clk);
        if (tap_out && !prev_tap) begin
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                mon_vectors++;
                if (since != e) begin
                    mon_misses++;
                    $display("FAIL %s: actual %0d expected %0d", t, since, e);
                end
            end
            since = 0;
        end
        prev_tap = tap_out;
    end

    task automatic run_divide(bit byp, int k);
        int n;
        @(negedge clk);
        clear = 1'b1; skip_low = byp; tap_sel = 3'(k); pulse_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        n = byp ? k + 1 : k + 1 + SM_SECT;
        exp_q.push_back(1 << (n - 1));
        tag_q.push_back($sformatf("R4 first rise sel=%0d bypass=%0d", k, byp));
        exp_q.push_back(1 << n);
        tag_q.push_back($sformatf("%s period sel=%0d", byp ? "R3" : "R2", k));
        clear = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==",
                 vectors + mon_vectors, misses + mon_misses);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int highs;
        int doubles;
        logic last;
        repeat (3) @(negedge clk);
        check("R1 reset count", count_o, 0);
        check("R1 reset tap", tap_out, 0);
        check("R1 reset count full build", full_count, 0);
        rst = 1'b0;

        for (int k = 0; k < 8; k++) run_divide(1'b0, k);
        for (int k = 0; k < 8; k++) run_divide(1'b1, k);

        // R7: holds freeze the chain
        @(negedge clk); clear = 1'b1; skip_low = 1'b1; tap_sel = 3'd0;
        @(negedge clk); clear = 1'b0; clk_hold = 1'b1;
        repeat (5) @(negedge clk);
        check("R7 clock hold count", count_o, 0);
        check("R7 clock hold tap", tap_out, 0);
        clk_hold = 1'b0; osc_hold = 1'b1;
        repeat (5) @(negedge clk);
        check("R7 oscillator hold count", count_o, 0);
        osc_hold = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 bypass count after 3", count_o, 12'h030);

        // R6 preset, then R3 low section held while upper wraps
        preset = 1'b1; skip_low = 1'b0;
        @(negedge clk);
        check("R6 preset count", count_o, 12'hFFF);
        check("R6 preset tap", tap_out, 1);
        preset = 1'b0; skip_low = 1'b1;
        @(negedge clk);
        check("R3 bypass wrap keeps low section", count_o, 12'h00F);

        // R5 clear priority
        preset = 1'b1; clk_hold = 1'b1;
        @(negedge clk);
        check("R6 preset under hold", count_o, 12'hFFF);
        preset = 1'b1; clear = 1'b1; skip_low = 1'b0;
        @(negedge clk);
        check("R5 clear over preset and hold", count_o, 0);
        preset = 1'b0; clk_hold = 1'b0;
        @(negedge clk);
        clear = 1'b0;

        // R8 test configuration
        skip_low = 1'b1; preset = 1'b1; clear = 1'b1;
        repeat (15) @(negedge clk);
        check("R8 narrow build after 15", count_o, 12'hFFF);
        check("R8 full build after 15", full_count, 24'h0F0F0F);
        repeat (240) @(negedge clk);
        check("R8 narrow build after 255", count_o, 12'hFFF);
        check("R8 full build after 255", full_count, 24'hFFFFFF);
        @(negedge clk);
        check("R8 full build after 256", full_count, 0);
        check("R8 narrow build after 256", count_o, 0);
        preset = 1'b0; skip_low = 1'b0;
        @(negedge clk);
        check("R5 clear after test", count_o, 0);

        // R9 pulse mode
        pulse_mode = 1'b1; skip_low = 1'b1; tap_sel = 3'd1;
        @(negedge clk); clear = 1'b0;
        highs = 0; doubles = 0; last = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (tap_out) highs++;
            if (tap_out && last) doubles++;
            last = tap_out;
        end
        check("R9 pulse count in 16 clocks", highs, 4);
        check("R9 pulse width one clock", doubles, 0);

        done = 1'b1;
        report();
    end

endmodule